// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block runs external memory cycles over two 8-bit general-purpose ports that it borrows from the core for the length of each cycle. The low port carries the low address byte first. It then turns round and carries the data byte. The high port holds the upper address byte for the whole cycle, so no external latch is needed for it. An address-latch-enable pulse marks the time when the low port carries address. An external latch captures that byte on the pulse's falling edge. One of three active-low strobes then runs the cycle: program fetch, data read or data write.

The core places one request at a time. Each request gives a kind, an address, a width flag and, for a write, a data byte. The block reports `busy` while the cycle runs. It pulses `done` on the last cycle and returns the read byte on `rdata`. Every cycle has four phases of `PHASE_LEN` clocks each: address, address hold, strobe and recovery. When a cycle ends, the high port goes back to its latch value. The low-port latch is left at all ones, because its pins served as the data bus. A short (8-bit) data access does not drive the high port. The external memory then sees whatever the core last wrote into the high-port latch as the upper address byte.

Top module: `xbus_seq`

## Requirements
- R1: After reset, `busy`, `done` and `ale` are 0. `psen_n`, `rd_n` and `wr_n` are 1. Both port latches hold 8'hFF, so `hi_out` = 8'hFF, `lo_out` = 8'hFF and `lo_oe` = 8'h00.
- R2: A request accepted in idle starts the cycle on the next clock. During the address and hold phases (2*PHASE_LEN cycles), `lo_out` carries address bits 7:0 and `lo_oe` = 8'hFF. `ale` is 1 only in the first PHASE_LEN of these cycles. A latch that captures `lo_out` on the falling edge of `ale` therefore holds address bits 7:0.
- R3: Throughout `busy`, `hi_out` is stable. For a fetch, or when `req_wide` = 1, it equals address bits 15:8. For a data access with `req_wide` = 0, it equals the high-port latch.
- R4: `req_kind` 2'b00 (fetch) strobes `psen_n` and always drives the full 16-bit address, whatever `req_wide` is.
- R5: `req_kind` 2'b01 and 2'b11 are data reads and strobe `rd_n`. `lo_oe` = 8'h00 during the strobe and recovery phases of any read or fetch. `rdata` is sampled from `lo_in` in the last strobe cycle and is valid while `done` = 1.
- R6: `req_kind` 2'b10 is a data write and strobes `wr_n`. `lo_out` = `req_wdata` with `lo_oe` = 8'hFF from the first strobe-phase cycle, which is one cycle before `wr_n` falls, until the end of recovery, which is at least one cycle after `wr_n` rises.
- R7: At most one of `psen_n`, `rd_n` and `wr_n` is low at a time. None is low while `ale` = 1. Each falls only after `ale` has been low for at least a full cycle. A strobe stays low for PHASE_LEN-1 cycles.
- R8: `busy` lasts exactly 4*PHASE_LEN cycles. `done` is a one-cycle pulse on the last of them. A `req_valid` that arrives while `busy` = 1 is ignored.
- R9: After a cycle, `hi_out` shows the high-port latch again. The low-port latch is overwritten with 8'hFF, so idle `lo_out` = 8'hFF and `lo_oe` = 8'h00.
- R10: While idle, `lat_we_hi` or `lat_we_lo` loads `lat_wdata` into that port's latch, and the new value is seen on the next cycle. While `busy` = 1, latch writes are ignored.
- R11: The low port is open-drain when idle: `lo_out` = latch and `lo_oe` = bitwise inverse of the latch. A latch bit of 1 lets the pin float and act as an input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Cycle request, taken when idle |
| req_kind | input | 2 | 00 fetch, 01/11 data read, 10 data write |
| req_wide | input | 1 | 1: 16-bit data address, 0: 8-bit data address |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | Last cycle of the bus cycle |
| rdata | output | 8 | Read or fetch data |
| lat_we_lo | input | 1 | Low-port latch write |
| lat_we_hi | input | 1 | High-port latch write |
| lat_wdata | input | 8 | Latch write value |
| lo_out | output | 8 | Low-port output value |
| lo_oe | output | 8 | Low-port per-bit output enable |
| lo_in | input | 8 | Low-port pin value |
| hi_out | output | 8 | High-port output value |
| ale | output | 1 | Address latch enable, active high |
| psen_n | output | 1 | Program read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |

## Verification
The main table covers fetches with the width flag both set and clear, which tells whether a fetch is forced to a 16-bit address. It also covers wide and short data reads and writes. Each of these uses a different high-latch preset, so a short access that wrongly drives the request's upper byte, or a wide one that shows the latch, lands on a different memory byte. Read data comes from a memory model that is addressed through a model latch clocked by `ale`. Reads therefore also test the address phase, and writes test that data is on the bus while `wr_n` is low. Directed tests cover the reset state, latch loads while idle, and latch writes and requests that arrive mid-cycle, which must leave no trace.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [1:0] {
    KIND_FETCH  = 2'b00,
    KIND_RD     = 2'b01,
    KIND_WR     = 2'b10,
    KIND_RD_ALT = 2'b11
  } xkind_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_HOLD,
    PH_STRB,
    PH_RECOV
  } xphase_e;

  function automatic xphase_e phase_after(input xphase_e p);
    case (p)
      PH_ADDR:  return PH_HOLD;
      PH_HOLD:  return PH_STRB;
      PH_STRB:  return PH_RECOV;
      default:  return PH_IDLE;
    endcase
  endfunction

  function automatic logic is_fetch(input xkind_e k);
    return k == KIND_FETCH;
  endfunction

  function automatic logic is_write(input xkind_e k);
    return k == KIND_WR;
  endfunction

  // the request's upper byte goes on the high port only for fetches and wide accesses
  function automatic logic drives_high(input xkind_e k, input logic wide);
    return is_fetch(k) || wide;
  endfunction

  function automatic int unsigned cycle_span(input int unsigned plen);
    return 4 * plen;
  endfunction

endpackage

// File: rtl/xbus_phase_ctrl.sv
module xbus_phase_ctrl
  import xbus_pkg::*;
#(
  parameter int unsigned PHASE_LEN = 2,
  parameter int unsigned BYTE_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [1:0]          req_kind,
  input  logic                req_wide,
  input  logic [2*BYTE_W-1:0] req_addr,
  input  logic [BYTE_W-1:0]   req_wdata,
  output xphase_e             phase,
  output logic                cnt_first,
  output logic                strb_last,
  output logic                busy,
  output logic                done,
  output xkind_e              cyc_kind,
  output logic                cyc_full,
  output logic [2*BYTE_W-1:0] cyc_addr,
  output logic [BYTE_W-1:0]   cyc_wdata
);
  localparam int unsigned CW = (PHASE_LEN > 2) ? $clog2(PHASE_LEN) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(PHASE_LEN - 1);

  logic [CW-1:0] cnt;
  logic          cnt_last;
  logic          accept;

  assign cnt_last  = (cnt == CNT_LAST);
  assign cnt_first = (cnt == '0);
  assign busy      = (phase != PH_IDLE);
  assign accept    = req_valid && !busy;
  assign done      = (phase == PH_RECOV) && cnt_last;
  assign strb_last = (phase == PH_STRB) && cnt_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      cyc_kind  <= KIND_FETCH;
      cyc_full  <= 1'b0;
      cyc_addr  <= '0;
      cyc_wdata <= '0;
    end else if (accept) begin
      phase     <= PH_ADDR;
      cnt       <= '0;
      cyc_kind  <= xkind_e'(req_kind);
      cyc_full  <= drives_high(xkind_e'(req_kind), req_wide);
      cyc_addr  <= req_addr;
      cyc_wdata <= req_wdata;
    end else if (busy) begin
      if (cnt_last) begin
        cnt   <= '0;
        phase <= phase_after(phase);
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/xbus_strobe_gen.sv
module xbus_strobe_gen
  import xbus_pkg::*;
(
  input  xphase_e phase,
  input  logic    cnt_first,
  input  xkind_e  cyc_kind,
  output logic    ale,
  output logic    psen_n,
  output logic    rd_n,
  output logic    wr_n
);
  logic strb_on;

  assign ale = (phase == PH_ADDR);

  // the first strobe-phase cycle is set-up time: the bus turns round before the strobe falls
  assign strb_on = (phase == PH_STRB) && !cnt_first;

  always_comb begin
    psen_n = 1'b1;
    rd_n   = 1'b1;
    wr_n   = 1'b1;
    if (strb_on) begin
      if (is_fetch(cyc_kind))      psen_n = 1'b0;
      else if (is_write(cyc_kind)) wr_n   = 1'b0;
      else                         rd_n   = 1'b0;
    end
  end

endmodule

// File: rtl/xbus_port_mux.sv
module xbus_port_mux
  import xbus_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  xphase_e             phase,
  input  logic                busy,
  input  logic                done,
  input  logic                strb_last,
  input  xkind_e              cyc_kind,
  input  logic                cyc_full,
  input  logic [2*BYTE_W-1:0] cyc_addr,
  input  logic [BYTE_W-1:0]   cyc_wdata,
  input  logic                lat_we_lo,
  input  logic                lat_we_hi,
  input  logic [BYTE_W-1:0]   lat_wdata,
  input  logic [BYTE_W-1:0]   lo_in,
  output logic [BYTE_W-1:0]   lo_out,
  output logic [BYTE_W-1:0]   lo_oe,
  output logic [BYTE_W-1:0]   hi_out,
  output logic [BYTE_W-1:0]   rdata
);
  localparam logic [BYTE_W-1:0] ONES = {BYTE_W{1'b1}};

  logic [BYTE_W-1:0] lo_latch;
  logic [BYTE_W-1:0] hi_latch;
  logic              addr_phase;
  logic              data_phase;

  assign addr_phase = (phase == PH_ADDR) || (phase == PH_HOLD);
  assign data_phase = (phase == PH_STRB) || (phase == PH_RECOV);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_latch <= ONES;
      hi_latch <= ONES;
    end else begin
      if (done)                   lo_latch <= ONES;
      else if (lat_we_lo && !busy) lo_latch <= lat_wdata;
      if (lat_we_hi && !busy)     hi_latch <= lat_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                              rdata <= '0;
    else if (strb_last && !is_write(cyc_kind)) rdata <= lo_in;
  end

  always_comb begin
    if (addr_phase) begin
      lo_out = cyc_addr[BYTE_W-1:0];
      lo_oe  = ONES;
    end else if (data_phase && is_write(cyc_kind)) begin
      lo_out = cyc_wdata;
      lo_oe  = ONES;
    end else if (data_phase) begin
      lo_out = ONES;
      lo_oe  = '0;
    end else begin
      lo_out = lo_latch;
      lo_oe  = ~lo_latch;
    end
  end

  assign hi_out = (busy && cyc_full) ? cyc_addr[2*BYTE_W-1:BYTE_W] : hi_latch;

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int unsigned PHASE_LEN = 2,
  parameter int unsigned BYTE_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [1:0]          req_kind,
  input  logic                req_wide,
  input  logic [2*BYTE_W-1:0] req_addr,
  input  logic [BYTE_W-1:0]   req_wdata,
  output logic                busy,
  output logic                done,
  output logic [BYTE_W-1:0]   rdata,
  input  logic                lat_we_lo,
  input  logic                lat_we_hi,
  input  logic [BYTE_W-1:0]   lat_wdata,
  output logic [BYTE_W-1:0]   lo_out,
  output logic [BYTE_W-1:0]   lo_oe,
  input  logic [BYTE_W-1:0]   lo_in,
  output logic [BYTE_W-1:0]   hi_out,
  output logic                ale,
  output logic                psen_n,
  output logic                rd_n,
  output logic                wr_n
);
  xphase_e             phase;
  logic                cnt_first;
  logic                strb_last;
  xkind_e              cyc_kind;
  logic                cyc_full;
  logic [2*BYTE_W-1:0] cyc_addr;
  logic [BYTE_W-1:0]   cyc_wdata;

  xbus_phase_ctrl #(.PHASE_LEN(PHASE_LEN), .BYTE_W(BYTE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_kind(req_kind), .req_wide(req_wide),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .phase(phase), .cnt_first(cnt_first), .strb_last(strb_last),
    .busy(busy), .done(done),
    .cyc_kind(cyc_kind), .cyc_full(cyc_full),
    .cyc_addr(cyc_addr), .cyc_wdata(cyc_wdata)
  );

  xbus_strobe_gen u_strb (
    .phase(phase), .cnt_first(cnt_first), .cyc_kind(cyc_kind),
    .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n)
  );

  xbus_port_mux #(.BYTE_W(BYTE_W)) u_port (
    .clk(clk), .rst_n(rst_n),
    .phase(phase), .busy(busy), .done(done), .strb_last(strb_last),
    .cyc_kind(cyc_kind), .cyc_full(cyc_full),
    .cyc_addr(cyc_addr), .cyc_wdata(cyc_wdata),
    .lat_we_lo(lat_we_lo), .lat_we_hi(lat_we_hi), .lat_wdata(lat_wdata),
    .lo_in(lo_in), .lo_out(lo_out), .lo_oe(lo_oe), .hi_out(hi_out),
    .rdata(rdata)
  );

endmodule

// File: rtl/xbus_seq_chk.sv
module xbus_seq_chk
  import xbus_pkg::*;
#(
  parameter int unsigned PHASE_LEN = 2,
  parameter int unsigned BYTE_W    = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              ale,
  input logic              psen_n,
  input logic              rd_n,
  input logic              wr_n,
  input logic [BYTE_W-1:0] lo_out,
  input logic [BYTE_W-1:0] lo_oe,
  input logic [BYTE_W-1:0] hi_out
);
  localparam int unsigned SPAN = cycle_span(PHASE_LEN);
  localparam logic [BYTE_W-1:0] ONES = {BYTE_W{1'b1}};

  logic [15:0] run_len;
  logic        any_strb;

  assign any_strb = !psen_n || !rd_n || !wr_n;

  always_ff @(posedge clk) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!psen_n, !rd_n, !wr_n}));

  // R7
  ale_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> !any_strb);

  // R7
  strobe_after_ale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(psen_n) || $fell(rd_n) || $fell(wr_n)) |-> (!ale && !$past(ale)));

  // R2
  ale_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (lo_oe == ONES));

  // R5
  read_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !psen_n) |-> (lo_oe == '0));

  // R6
  wr_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_n) |-> ($past(lo_oe) == ONES && $stable(lo_out)));

  // R6
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> (lo_oe == ONES && $stable(lo_out)));

  // R3
  hi_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(hi_out));

  // R8
  busy_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_len < 16'(SPAN)));

  // R8
  done_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy && run_len == 16'(SPAN - 1)));

  // R8
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ale && !any_strb));

endmodule

bind xbus_seq xbus_seq_chk #(.PHASE_LEN(PHASE_LEN), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .ale(ale),
  .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
  .lo_out(lo_out), .lo_oe(lo_oe), .hi_out(hi_out)
);

// File: tb/sim_xbus_seq.sv
`timescale 1ns/1ps
module sim_xbus_seq;
  localparam int PH = 3;
  localparam int NV = 8;
  // {kind[34:33], wide[32], addr[31:16], wdata[15:8], high-latch preset[7:0]}
  localparam logic [34:0] VECS [NV] = '{
    {2'b00, 1'b1, 16'h1234, 8'h00, 8'hC3},
    {2'b00, 1'b0, 16'hABCD, 8'h00, 8'h21},
    {2'b01, 1'b1, 16'h8001, 8'h00, 8'h5E},
    {2'b01, 1'b0, 16'h55AA, 8'h00, 8'h77},
    {2'b10, 1'b1, 16'hFFFF, 8'h00, 8'h12},
    {2'b10, 1'b0, 16'h0010, 8'hA5, 8'h3E},
    {2'b11, 1'b1, 16'h0F0F, 8'h00, 8'h90},
    {2'b01, 1'b0, 16'hEE46, 8'h00, 8'h00}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_kind = 2'b00;
  logic req_wide = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic lat_we_lo = 1'b0, lat_we_hi = 1'b0;
  logic [7:0] lat_wdata = '0;
  logic busy, done, ale, psen_n, rd_n, wr_n;
  logic [7:0] rdata, lo_out, lo_oe, lo_in, hi_out;
  logic [7:0] alat = '0;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  function automatic logic [7:0] membyte(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
  endfunction

  // external address latch and memory models
  always @(negedge ale) alat = lo_out;
  assign lo_in = (!rd_n || !psen_n) ? membyte({hi_out, alat}) : 8'hFF;

  xbus_seq #(.PHASE_LEN(PH)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rdata(rdata),
    .lat_we_lo(lat_we_lo), .lat_we_hi(lat_we_hi), .lat_wdata(lat_wdata),
    .lo_out(lo_out), .lo_oe(lo_oe), .lo_in(lo_in), .hi_out(hi_out),
    .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_latches(input logic [7:0] v);
    lat_we_hi = 1'b1; lat_we_lo = 1'b1; lat_wdata = v;
    @(negedge clk);
    lat_we_hi = 1'b0; lat_we_lo = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [34:0] v;
    logic [1:0] kind;
    logic wide;
    logic [15:0] addr, full;
    logic [7:0] wd, hp, got;
    logic [2:0] exp_strb;
    int nbusy, nale, nstrb, ndone, bad_strb, bad_hi, bad_bus, aleseq_bad;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !ale, "R1 ctrl idle", {busy, done, ale}, 0);
    chk({psen_n, rd_n, wr_n} == 3'b111, "R1 strobes", {psen_n, rd_n, wr_n}, 3'b111);
    chk(hi_out == 8'hFF && lo_out == 8'hFF && lo_oe == 8'h00, "R1 ports",
        {hi_out, lo_out, lo_oe}, 24'hFFFF00);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && lo_oe == 8'h00, "R1 after release", {busy, lo_oe}, 0);

    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      kind = v[34:33]; wide = v[32]; addr = v[31:16]; wd = v[15:8]; hp = v[7:0];
      load_latches(hp);
      // R10 / R11: idle latch load seen next cycle, low port open-drain
      chk(hi_out == hp, "R10 hi latch load", hi_out, hp);
      chk(lo_out == hp && lo_oe == ~hp, "R11 open-drain idle", {lo_out, lo_oe}, {hp, ~hp});
      full = (kind == 2'b00 || wide) ? addr : {hp, addr[7:0]};
      exp_strb = (kind == 2'b00) ? 3'b100 : (kind == 2'b10) ? 3'b001 : 3'b010;
      req_valid = 1'b1; req_kind = kind; req_wide = wide; req_addr = addr; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      nbusy = 0; nale = 0; nstrb = 0; ndone = 0; bad_strb = 0; bad_hi = 0; bad_bus = 0;
      aleseq_bad = 0; got = 8'h00;
      while (busy && nbusy < 64) begin
        if (ale) begin
          nale++;
          if (nbusy >= PH) aleseq_bad++;
        end
        if (nbusy < 2 * PH && (lo_out != addr[7:0] || lo_oe != 8'hFF)) bad_bus++;
        if (hi_out != full[15:8]) bad_hi++;
        if (!psen_n || !rd_n || !wr_n) begin
          nstrb++;
          if ({!psen_n, !rd_n, !wr_n} != exp_strb) bad_strb++;
        end
        if (nbusy >= 2 * PH) begin
          if (kind == 2'b10) begin
            if (lo_out != wd || lo_oe != 8'hFF) bad_bus++;
          end else if (lo_oe != 8'h00) bad_bus++;
        end
        if (done) begin ndone++; got = rdata; end
        nbusy++;
        @(negedge clk);
      end
      chk(nbusy == 4 * PH && ndone == 1, "R8 busy length and done pulse", {nbusy[15:0], ndone[15:0]},
          {16'(4 * PH), 16'd1});
      chk(nale == PH && aleseq_bad == 0, "R2 ale window", nale, PH);
      chk(alat == full[7:0] && bad_bus == 0, "R2/R5/R6 low port use", {alat, bad_bus[7:0]}, {full[7:0], 8'h00});
      chk(bad_hi == 0, "R3 high port during cycle", bad_hi, 0);
      chk(nstrb == PH - 1 && bad_strb == 0, "R4/R5/R6/R7 strobe select", {nstrb[7:0], bad_strb[7:0]},
          {8'(PH - 1), 8'h00});
      if (kind != 2'b10)
        chk(got == membyte(full), "R4/R5 read data", got, membyte(full));
      chk(hi_out == hp, "R9 high latch restored", hi_out, hp);
      chk(lo_out == 8'hFF && lo_oe == 8'h00, "R9 low latch overwritten", {lo_out, lo_oe}, 16'hFF00);
    end

    // R8 / R10: requests and latch writes during a cycle are ignored
    load_latches(8'h42);
    req_valid = 1'b1; req_kind = 2'b01; req_wide = 1'b1; req_addr = 16'h9009;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    lat_we_hi = 1'b1; lat_we_lo = 1'b1; lat_wdata = 8'h11;
    req_valid = 1'b1; req_kind = 2'b10; req_addr = 16'h0000;
    @(negedge clk);
    lat_we_hi = 1'b0; lat_we_lo = 1'b0; req_valid = 1'b0;
    chk(hi_out == 8'h90, "R3 wide read high byte", hi_out, 8'h90);
    for (int k = 0; k < 40 && busy; k++) @(negedge clk);
    chk(hi_out == 8'h42, "R10 high latch write ignored while busy", hi_out, 8'h42);
    chk(lo_out == 8'hFF, "R10 low latch write ignored while busy", lo_out, 8'hFF);
    for (int k = 0; k < 3; k++) begin
      chk(!busy && wr_n, "R8 request during busy ignored", {busy, wr_n}, 2'b01);
      @(negedge clk);
    end

    finish_run();
  end

endmodule